// File: doc/BRIEF.md
# FP Access Trap Router

This block decides, once per instruction, whether a floating-point or SIMD operation may proceed, and if not, which exception level must take the resulting trap. It evaluates three layers of access control in priority order: the EL1 access-control field, then the EL2 trap bit, then the EL3 trap bit. The decision takes account of the current exception level, the execution width, the security state, and whether EL3 runs in 64-bit mode.

The result is a 2-bit target-level code in which zero means access is allowed. The code is captured on an instruction-valid strobe and held until the next strobe. A 1-bit trap flag accompanies the code, so that downstream logic can test for a trap without decoding the level. Raising the exception and building the syndrome are left to the consumer.

Top module: `fpt_router`

## Requirements
- R1: Reset (rst_n low) drives tgt_el_q to 0 and trap_q to 0.
- R2: tgt_el_q and trap_q change only on the clock edge after a cycle with insn_vld high. When insn_vld is low they hold their values.
- R3: When legacy_core is 1, the captured code is 0 whatever the control inputs hold.
- R4: With el1_en field 0 or 2, an access at EL0 or EL1 gives code 3 if is_secure=1 and el3_w64=0. Otherwise it gives code 1.
- R5: With el1_en field 0 or 2, an access at EL3 while cur_w64=0 gives code 3.
- R6: With el1_en field 1, an access at EL0 gives code 1. An access at EL1 is not stopped by this layer.
- R7: With el1_en field 3, the EL1 layer never traps.
- R8: When the EL1 layer does not trap, el2_trap=1 gives code 2, but only if cur_el<=2 and is_secure=0. A secure access, or one at EL3, ignores el2_trap.
- R9: When neither the EL1 layer nor the EL2 trap applies, el3_trap=1 gives code 3 at any level. Otherwise the code is 0.
- R10: The EL1 layer takes priority over the EL2 trap, and the EL2 trap takes priority over the EL3 trap.
- R11: trap_q is 1 exactly when tgt_el_q is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld | input | 1 | Instruction-valid strobe; captures a new decision |
| cur_el | input | 2 | Current exception level 0..3 |
| cur_w64 | input | 1 | 1 when executing in 64-bit mode |
| is_secure | input | 1 | 1 when in secure state |
| el3_w64 | input | 1 | 1 when EL3 runs in 64-bit mode |
| legacy_core | input | 1 | 1 for a core older than v6; FP is then always allowed |
| el1_en | input | 2 | EL1 FP enable field (0/2 trap EL0+EL1, 1 trap EL0, 3 none) |
| el2_trap | input | 1 | EL2 FP trap control bit |
| el3_trap | input | 1 | EL3 FP trap control bit |
| tgt_el_q | output | 2 | Registered trap target level; 0 means access allowed |
| trap_q | output | 1 | Registered trap flag, set when tgt_el_q is nonzero |

## Verification
The bench covers several corner cases, each of which a faulty design would get visibly wrong:

- **Secure 32-bit EL3 takeover.** A secure EL1 access with EL3 in 32-bit mode must route to EL3. A design that ignored this would send it to EL1.
- **Secure-state test on the EL2 bit.** The bench drives secure and non-secure EL1 accesses with el2_trap set. A design with the secure test reversed would trap the secure access to EL2 and let the non-secure one through.
- **Layer priority.** All three layers are armed at once. A reversed priority would report 3 or 2 where 1 is expected.
- **Legacy override and hold behaviour.** The legacy flag must force zero under every trap setting. The output must keep its value while the strobe is low, which would fail if the register loaded on every cycle.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int EL_W = 2;
  localparam int EN_W = 2;

  typedef logic [EL_W-1:0] el_t;

  localparam el_t EL_NONE = 2'd0;
  localparam el_t EL_1    = 2'd1;
  localparam el_t EL_2    = 2'd2;
  localparam el_t EL_3    = 2'd3;

  // One layer's verdict: hit means it claims the trap
  typedef struct packed {
    logic hit;
    el_t  tgt;
  } verdict_t;
endpackage

// File: rtl/fpt_el1_layer.sv
module fpt_el1_layer
  import fpt_pkg::*;
(
  input  el_t             cur_el,
  input  logic            cur_w64,
  input  logic            is_secure,
  input  logic            el3_w64,
  input  logic [EN_W-1:0] el1_en,
  output verdict_t        vd
);
  always_comb begin
    vd = '{hit: 1'b0, tgt: EL_NONE};
    unique case (el1_en)
      2'd0, 2'd2: begin
        if (cur_el == EL_NONE || cur_el == EL_1) begin
          vd.hit = 1'b1;
          vd.tgt = (is_secure && !el3_w64) ? EL_3 : EL_1;
        end else if (cur_el == EL_3 && !cur_w64) begin
          vd.hit = 1'b1;
          vd.tgt = EL_3;
        end
      end
      2'd1: begin
        if (cur_el == EL_NONE) begin
          vd.hit = 1'b1;
          vd.tgt = EL_1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpt_upper_layers.sv
module fpt_upper_layers
  import fpt_pkg::*;
(
  input  el_t      cur_el,
  input  logic     is_secure,
  input  logic     el2_trap,
  input  logic     el3_trap,
  output verdict_t vd_el2,
  output verdict_t vd_el3
);
  always_comb begin
    vd_el2.hit = el2_trap && (cur_el <= EL_2) && !is_secure;
    vd_el2.tgt = EL_2;
    vd_el3.hit = el3_trap;
    vd_el3.tgt = EL_3;
  end
endmodule

// File: rtl/fpt_router.sv
module fpt_router
  import fpt_pkg::*;
#(
  parameter int N_LAYERS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_vld,
  input  logic [1:0] cur_el,
  input  logic       cur_w64,
  input  logic       is_secure,
  input  logic       el3_w64,
  input  logic       legacy_core,
  input  logic [1:0] el1_en,
  input  logic       el2_trap,
  input  logic       el3_trap,
  output logic [1:0] tgt_el_q,
  output logic       trap_q
);
  verdict_t layers [N_LAYERS];
  el_t      tgt_d;
  el_t      tgt_r;
  logic     trap_r;

  fpt_el1_layer u_el1 (
    .cur_el    (cur_el),
    .cur_w64   (cur_w64),
    .is_secure (is_secure),
    .el3_w64   (el3_w64),
    .el1_en    (el1_en),
    .vd        (layers[0])
  );

  fpt_upper_layers u_up (
    .cur_el    (cur_el),
    .is_secure (is_secure),
    .el2_trap  (el2_trap),
    .el3_trap  (el3_trap),
    .vd_el2    (layers[1]),
    .vd_el3    (layers[2])
  );

  // Priority pick: lowest-index layer that hits wins
  always_comb begin
    tgt_d = EL_NONE;
    for (int i = N_LAYERS - 1; i >= 0; i--) begin
      if (layers[i].hit) tgt_d = layers[i].tgt;
    end
    if (legacy_core) tgt_d = EL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_r  <= EL_NONE;
      trap_r <= 1'b0;
    end else if (insn_vld) begin
      tgt_r  <= tgt_d;
      trap_r <= |tgt_d;
    end
  end

  assign tgt_el_q = tgt_r;
  assign trap_q   = trap_r;
endmodule

// File: rtl/fpt_router_chk.sv
module fpt_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_vld,
  input logic [1:0] cur_el,
  input logic       is_secure,
  input logic       legacy_core,
  input logic [1:0] el1_en,
  input logic       el2_trap,
  input logic       el3_trap,
  input logic [1:0] tgt_el_q,
  input logic       trap_q
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld |=> $stable(tgt_el_q) && $stable(trap_q));

  p_legacy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && legacy_core) |=> tgt_el_q == 2'd0);

  p_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && el1_en == 2'd3 && !el2_trap && !el3_trap) |=> tgt_el_q == 2'd0);

  p_el2_secure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && is_secure && !el3_trap) |=> tgt_el_q != 2'd2);

  p_el3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && !legacy_core && el3_trap) |=> tgt_el_q != 2'd0);

  p_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && !legacy_core && el1_en == 2'd1 && cur_el == 2'd0) |=> tgt_el_q == 2'd1);

  p_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q == (tgt_el_q != 2'd0));
endmodule

bind fpt_router fpt_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_vld    (insn_vld),
  .cur_el      (cur_el),
  .is_secure   (is_secure),
  .legacy_core (legacy_core),
  .el1_en      (el1_en),
  .el2_trap    (el2_trap),
  .el3_trap    (el3_trap),
  .tgt_el_q    (tgt_el_q),
  .trap_q      (trap_q)
);

// File: tb/fpt_router_tb.sv
module fpt_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       insn_vld;
  logic [1:0] cur_el;
  logic       cur_w64, is_secure, el3_w64, legacy_core;
  logic [1:0] el1_en;
  logic       el2_trap, el3_trap;
  logic [1:0] tgt_el_q;
  logic       trap_q;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpt_router dut_i (
    .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .cur_el(cur_el),
    .cur_w64(cur_w64), .is_secure(is_secure), .el3_w64(el3_w64),
    .legacy_core(legacy_core), .el1_en(el1_en), .el2_trap(el2_trap),
    .el3_trap(el3_trap), .tgt_el_q(tgt_el_q), .trap_q(trap_q)
  );

  task automatic check(input string req, input logic [1:0] exp_el);
    n_checks++;
    if (tgt_el_q !== exp_el || trap_q !== (exp_el != 2'd0)) begin
      n_errors++;
      $display("FAIL %s: tgt=%0d trap=%0d expected tgt=%0d trap=%0d",
               req, tgt_el_q, trap_q, exp_el, exp_el != 2'd0);
    end
  endtask

  // Drive inputs at the falling edge, strobe once, then sample at the next falling edge
  task automatic run(input logic [1:0] el, input logic w64, input logic sec,
                     input logic e3w, input logic leg, input logic [1:0] en,
                     input logic t2, input logic t3, input logic vld,
                     input string req, input logic [1:0] exp_el);
    @(negedge clk);
    cur_el = el; cur_w64 = w64; is_secure = sec; el3_w64 = e3w;
    legacy_core = leg; el1_en = en; el2_trap = t2; el3_trap = t3; insn_vld = vld;
    @(negedge clk);
    insn_vld = 1'b0;
    check(req, exp_el);
  endtask

  task automatic t_reset();
    check("R1", 2'd0);
  endtask

  task automatic t_el1_layer();
    run(2'd0, 1, 0, 1, 0, 2'd0, 0, 0, 1, "R4 ns el0", 2'd1);
    run(2'd1, 1, 1, 1, 0, 2'd2, 0, 0, 1, "R4 sec el3w64", 2'd1);
    run(2'd1, 0, 1, 0, 0, 2'd0, 0, 0, 1, "R4 sec el3w32", 2'd3);
    run(2'd3, 0, 1, 0, 0, 2'd2, 0, 0, 1, "R5 el3 w32", 2'd3);
    run(2'd3, 1, 1, 1, 0, 2'd0, 0, 0, 1, "R5 el3 w64 free", 2'd0);
    run(2'd0, 1, 0, 1, 0, 2'd1, 0, 0, 1, "R6 el0", 2'd1);
    run(2'd1, 1, 0, 1, 0, 2'd1, 0, 0, 1, "R6 el1 free", 2'd0);
    run(2'd0, 1, 0, 1, 0, 2'd3, 0, 0, 1, "R7 open", 2'd0);
  endtask

  task automatic t_upper();
    run(2'd1, 1, 0, 1, 0, 2'd3, 1, 0, 1, "R8 ns el1", 2'd2);
    run(2'd2, 1, 0, 1, 0, 2'd3, 1, 0, 1, "R8 el2", 2'd2);
    run(2'd1, 1, 1, 1, 0, 2'd3, 1, 0, 1, "R8 secure ignored", 2'd0);
    run(2'd3, 1, 0, 1, 0, 2'd3, 1, 0, 1, "R8 el3 ignored", 2'd0);
    run(2'd3, 1, 1, 1, 0, 2'd3, 0, 1, 1, "R9 el3 trap", 2'd3);
    run(2'd0, 1, 1, 1, 0, 2'd3, 1, 1, 1, "R9 secure el0", 2'd3);
  endtask

  task automatic t_priority();
    run(2'd0, 1, 0, 1, 0, 2'd0, 1, 1, 1, "R10 el1 wins", 2'd1);
    run(2'd1, 1, 0, 1, 0, 2'd1, 1, 1, 1, "R10 el2 wins", 2'd2);
  endtask

  task automatic t_legacy();
    run(2'd0, 0, 1, 0, 1, 2'd0, 1, 1, 1, "R3 legacy", 2'd0);
  endtask

  task automatic t_hold();
    run(2'd0, 1, 0, 1, 0, 2'd0, 0, 0, 1, "R11 load", 2'd1);
    run(2'd2, 1, 0, 1, 0, 2'd3, 0, 0, 0, "R2 hold no strobe", 2'd1);
    repeat (3) @(negedge clk);
    check("R2 hold long", 2'd1);
  endtask

  initial begin
    rst_n = 1'b0; insn_vld = 1'b0; cur_el = 2'd0; cur_w64 = 1'b0;
    is_secure = 1'b0; el3_w64 = 1'b0; legacy_core = 1'b0; el1_en = 2'd0;
    el2_trap = 1'b0; el3_trap = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_el1_layer();
    t_upper();
    t_priority();
    t_legacy();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: tgt=%0d expected run to finish", tgt_el_q);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule